// File: doc/BRIEF.md
# Signed Integer to Binary Floating-Point Converter

This block turns a signed two's-complement integer into an IEEE-754 binary floating-point value. The source is either 32 or 64 bits wide and the result is either single or double precision, so all four width pairings go through one datapath. The sign is taken off, the magnitude is formed, its leading one is located, the magnitude is shifted so that the leading one sits at the top, and the biased exponent is built from the leading-one position. Bits that do not fit in the fraction are then rounded in one of four modes.

A conversion is requested by a one-cycle `in_valid` strobe. The result comes out of registers one clock later with `out_valid`. If the rounded result differs from the source value, the block either pulses `inexact_trap` (when `trap_en` was high) or sets the sticky `inexact_sticky` flag (when it was low). The flag stays set until `clr_inexact` clears it.

Top module: `i2f_convert`

## Requirements
- R1: For a negative source the result sign bit is 1 and the two's-complement negation is converted as the magnitude. A non-negative source gives sign 0.
- R2: A zero source gives an all-zero result (positive zero) and neither pulses `inexact_trap` nor sets `inexact_sticky`.
- R3: The most negative source (-2^31 for a 32-bit source, -2^63 for a 64-bit source) converts exactly to minus that power of two, with no inexact signalling.
- R4: The biased exponent is the leading-one bit position of the magnitude plus 127 (single) or 1023 (double). `src_is_64`=0 converts sign-extended `src_data[31:0]` and ignores the upper half. `dst_is_dbl`=0 places the single result in `result[31:0]` with the upper half zero. With `dst_is_dbl`=1 the double fills `result[63:0]`.
- R5: `out_valid` and the result appear on the clock edge after the one that samples `in_valid`. `out_valid` is low in every other cycle.
- R6: `rnd_mode`=01 (toward zero) always truncates the discarded bits.
- R7: `rnd_mode`=10 (toward +inf) increments the truncated value only for a positive sign. `rnd_mode`=11 (toward -inf) increments it only for a negative sign. In both cases the increment happens only when discarded bits are nonzero.
- R8: `rnd_mode`=00 (nearest) increments when the discarded bits exceed half an LSB. On an exact half it increments only when the fraction LSB is 1.
- R9: The rounding increment acts on the combined exponent and fraction field, so a carry out of an all-ones fraction raises the exponent by one and leaves the fraction zero.
- R10: A 32-bit source converted to double is always exact and never signals inexact, even with `trap_en`=1.
- R11: An inexact conversion with `trap_en`=1 still delivers the rounded result, pulses `inexact_trap` for exactly one cycle, and leaves `inexact_sticky` unchanged.
- R12: An inexact conversion with `trap_en`=0 sets `inexact_sticky` and does not pulse `inexact_trap`.
- R13: `inexact_sticky` holds its value until `clr_inexact` clears it on a clock edge. If an inexact event (with `trap_en`=0) arrives in the same cycle as a clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Conversion request strobe |
| src_data | input | 64 | Integer source (lower 32 bits used for 32-bit sources) |
| src_is_64 | input | 1 | 1: 64-bit source, 0: 32-bit source |
| dst_is_dbl | input | 1 | 1: double result, 0: single result |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| trap_en | input | 1 | Inexact trap enable |
| clr_inexact | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Packed floating-point result |
| inexact_sticky | output | 1 | Sticky inexact status |
| inexact_trap | output | 1 | One-cycle inexact exception pulse |

## Verification
The hardest case to reach is a round-up that carries out of an all-ones fraction into the exponent. It needs a source whose kept bits are all ones and whose discarded bits force an increment. The stimulus uses 2^31-1 into single precision under nearest and toward-zero rounding, which gives two results with different exponents. Exact halfway cases are also narrow targets. They are reached with 2^24+1 and 2^24+3 for single and with 2^53+1 for double, so that the even-LSB and odd-LSB tie branches both occur. A final case drives an inexact event and a clear in the same cycle to check that the set wins.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_BIAS   = 127;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int DBL_BIAS   = 1023;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_UP      = 2'b10,
    RND_DOWN    = 2'b11
  } rnd_mode_e;

  // Decide whether the truncated value must be incremented.
  function automatic logic round_increment(input rnd_mode_e mode,
                                           input logic neg,
                                           input logic lsb,
                                           input logic guard,
                                           input logic sticky);
    logic lost;
    lost = guard | sticky;
    case (mode)
      RND_NEAREST: round_increment = guard & (sticky | lsb);
      RND_ZERO:    round_increment = 1'b0;
      RND_UP:      round_increment = lost & ~neg;
      default:     round_increment = lost & neg;
    endcase
  endfunction

  // Two's-complement magnitude; the most negative value maps to 2^(W-1).
  function automatic logic [63:0] magnitude64(input logic [63:0] v);
    magnitude64 = v[63] ? (~v + 64'd1) : v;
  endfunction

endpackage

// File: rtl/i2f_lead_one.sv
module i2f_lead_one #(
  parameter int W     = 64,
  parameter int SEG_W = 32,
  localparam int NSEG   = W / SEG_W,
  localparam int POS_W  = $clog2(W),
  localparam int SEG_PW = $clog2(SEG_W)
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [POS_W-1:0] pos
);

  logic [NSEG-1:0]        seg_any;
  logic [NSEG*SEG_PW-1:0] seg_pos_flat;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W-1:0]  seg;
    logic [SEG_PW-1:0] p;
    assign seg = vec[g*SEG_W +: SEG_W];
    always_comb begin
      p = '0;
      for (int b = 0; b < SEG_W; b++) begin
        if (seg[b]) p = SEG_PW'(b);
      end
    end
    assign seg_any[g] = |seg;
    assign seg_pos_flat[g*SEG_PW +: SEG_PW] = p;
  end

  // Upper segments override lower ones: the highest nonzero word wins.
  always_comb begin
    pos = '0;
    for (int g = 0; g < NSEG; g++) begin
      if (seg_any[g]) pos = POS_W'(g * SEG_W) + POS_W'(seg_pos_flat[g*SEG_PW +: SEG_PW]);
    end
  end

  assign found = |seg_any;

  // R4: the reported position holds a one and nothing above it is set
  always_comb begin
    if (found) begin
      p_lead_is_one_r4: assert (vec[pos] == 1'b1);
      p_nothing_above_r4: assert ((vec >> pos) == W'(1));
    end
  end

endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int BIAS   = 127,
  parameter int W      = 64,
  localparam int POS_W = $clog2(W),
  localparam int FLD_W = EXP_W + FRAC_W,
  localparam int GRD_B = W - 2 - FRAC_W
) (
  input  logic [W-1:0]     norm,
  input  logic [POS_W-1:0] pos,
  input  logic             neg,
  input  rnd_mode_e        mode,
  output logic [FLD_W-1:0] field,
  output logic             inexact
);

  logic [EXP_W-1:0]  exp_b;
  logic [FRAC_W-1:0] frac_t;
  logic [FLD_W-1:0]  trunc;
  logic              guard_bit;
  logic              sticky_bit;
  logic              bump;

  assign exp_b      = EXP_W'(BIAS) + EXP_W'(pos);
  assign frac_t     = norm[W-2 -: FRAC_W];
  assign trunc      = {exp_b, frac_t};
  assign guard_bit  = norm[GRD_B];
  assign sticky_bit = |norm[GRD_B-1:0];
  assign bump       = round_increment(mode, neg, frac_t[0], guard_bit, sticky_bit);
  assign inexact    = guard_bit | sticky_bit;
  assign field      = trunc + FLD_W'(bump);

  // R9: the increment may carry into the exponent but never wraps the field
  always_comb begin
    if (bump) p_no_wrap_r9: assert (field > trunc);
  end

endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
  import i2f_pkg::*;
#(
  parameter int SRC_W = 64,
  parameter int SEG_W = 32,
  localparam int HALF_W = SRC_W / 2,
  localparam int POS_W  = $clog2(SRC_W),
  localparam int SGL_W  = 1 + SGL_EXP_W + SGL_FRAC_W,
  localparam int DBL_W  = 1 + DBL_EXP_W + DBL_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SRC_W-1:0]  src_data,
  input  logic              src_is_64,
  input  logic              dst_is_dbl,
  input  logic [1:0]        rnd_mode,
  input  logic              trap_en,
  input  logic              clr_inexact,
  output logic              out_valid,
  output logic [SRC_W-1:0]  result,
  output logic              inexact_sticky,
  output logic              inexact_trap
);

  // ---- sign and magnitude ----
  logic [SRC_W-1:0] src_ext;
  logic             src_neg;
  logic [SRC_W-1:0] mag;
  logic             zero_src;

  assign src_ext  = src_is_64 ? src_data
                              : {{HALF_W{src_data[HALF_W-1]}}, src_data[HALF_W-1:0]};
  assign src_neg  = src_ext[SRC_W-1];
  assign mag      = magnitude64(src_ext);
  assign zero_src = ~(|mag);

  // ---- leading one and normalisation ----
  logic             lead_found;
  logic [POS_W-1:0] lead_pos;
  logic [SRC_W-1:0] norm;

  i2f_lead_one #(.W(SRC_W), .SEG_W(SEG_W)) u_lead (
    .vec   (mag),
    .found (lead_found),
    .pos   (lead_pos)
  );

  assign norm = mag << (POS_W'(SRC_W - 1) - lead_pos);

  // ---- one rounder per destination format ----
  logic [SGL_W-2:0] fld_sgl;
  logic [DBL_W-2:0] fld_dbl;
  logic             inx_sgl;
  logic             inx_dbl;
  rnd_mode_e        mode;

  assign mode = rnd_mode_e'(rnd_mode);

  i2f_round #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W), .BIAS(SGL_BIAS), .W(SRC_W)) u_rnd_sgl (
    .norm    (norm),
    .pos     (lead_pos),
    .neg     (src_neg),
    .mode    (mode),
    .field   (fld_sgl),
    .inexact (inx_sgl)
  );

  i2f_round #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W), .BIAS(DBL_BIAS), .W(SRC_W)) u_rnd_dbl (
    .norm    (norm),
    .pos     (lead_pos),
    .neg     (src_neg),
    .mode    (mode),
    .field   (fld_dbl),
    .inexact (inx_dbl)
  );

  // ---- result selection and event generation ----
  logic [SRC_W-1:0] packed_res;
  logic             exact_widen;
  logic             inexact_evt;

  assign exact_widen = dst_is_dbl & ~src_is_64;

  always_comb begin
    if (!lead_found)     packed_res = '0;
    else if (dst_is_dbl) packed_res = SRC_W'({src_neg, fld_dbl});
    else                 packed_res = SRC_W'({src_neg, fld_sgl});
  end

  assign inexact_evt = in_valid & lead_found & ~exact_widen &
                       (dst_is_dbl ? inx_dbl : inx_sgl);

  // ---- output registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result         <= '0;
      inexact_trap   <= 1'b0;
      inexact_sticky <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      inexact_trap <= inexact_evt & trap_en;
      if (in_valid) result <= packed_res;
      if (inexact_evt & ~trap_en) inexact_sticky <= 1'b1;
      else if (clr_inexact)       inexact_sticky <= 1'b0;
    end
  end

  // ---- assertions ----
  p_zero_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && zero_src |=> (result == '0) && !inexact_trap);

  p_sign_dbl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dst_is_dbl && !zero_src |=> result[SRC_W-1] == $past(src_neg));

  p_sign_sgl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dst_is_dbl |=> result[SRC_W-1:HALF_W] == '0);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_exact_widen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && exact_widen && !clr_inexact |=> !inexact_trap && $stable(inexact_sticky));

  p_trap_keeps_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && trap_en && !clr_inexact |=> $stable(inexact_sticky));

  p_trap_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_trap |-> $past(trap_en) && $past(in_valid));

  p_flag_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_evt && !trap_en |=> inexact_sticky && !inexact_trap);

  p_flag_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_sticky && !clr_inexact |=> inexact_sticky);

endmodule

// File: tb/test_i2f_convert.sv
module test_i2f_convert;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_data = '0;
  logic        src_is_64 = 1'b0;
  logic        dst_is_dbl = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        trap_en = 1'b0;
  logic        clr_inexact = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        inexact_sticky;
  logic        inexact_trap;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [1:0] M_NE = 2'b00, M_RZ = 2'b01, M_UP = 2'b10, M_DN = 2'b11;

  always #2.5 clk = ~clk;

  i2f_convert i_i2f_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_data(src_data),
    .src_is_64(src_is_64), .dst_is_dbl(dst_is_dbl), .rnd_mode(rnd_mode),
    .trap_en(trap_en), .clr_inexact(clr_inexact), .out_valid(out_valid),
    .result(result), .inexact_sticky(inexact_sticky), .inexact_trap(inexact_trap)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
    end
  endtask

  // Issue one conversion; on return the registered outputs are visible.
  task automatic convert(input logic [63:0] s, input logic s64, input logic dbl,
                         input logic [1:0] m, input logic te);
    @(negedge clk);
    src_data = s; src_is_64 = s64; dst_is_dbl = dbl; rnd_mode = m; trap_en = te;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    trap_en = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    clr_inexact = 1'b1;
    @(negedge clk);
    clr_inexact = 1'b0;
  endtask

  task automatic t_reset();
    check("R5 reset out_valid", 64'(out_valid), 64'd0);
    check("R4 reset result", result, 64'd0);
    check("R13 reset sticky", 64'(inexact_sticky), 64'd0);
    check("R11 reset trap", 64'(inexact_trap), 64'd0);
  endtask

  task automatic t_sign_basic();
    convert(64'd1, 1'b0, 1'b0, M_NE, 1'b0);
    check("R4 +1 single", result, 64'h3F80_0000);
    convert(64'hDEAD_BEEF_FFFF_FFFF, 1'b0, 1'b0, M_NE, 1'b0);
    check("R1 -1 single, upper half ignored", result, 64'hBF80_0000);
    convert(64'h0000_0001_0000_0000, 1'b1, 1'b0, M_NE, 1'b0);
    check("R4 2^32 from 64-bit to single", result, 64'h4F80_0000);
    convert(64'd5, 1'b1, 1'b1, M_NE, 1'b0);
    check("R4 5 from 64-bit lower word to double", result, 64'h4014_0000_0000_0000);
  endtask

  task automatic t_zero();
    clear_flag();
    convert(64'd0, 1'b1, 1'b1, M_UP, 1'b1);
    check("R2 zero result", result, 64'd0);
    check("R2 zero no trap", 64'(inexact_trap), 64'd0);
    check("R2 zero no sticky", 64'(inexact_sticky), 64'd0);
  endtask

  task automatic t_most_negative();
    convert(64'h0000_0000_8000_0000, 1'b0, 1'b0, M_NE, 1'b1);
    check("R3 -2^31 single", result, 64'hCF00_0000);
    check("R3 -2^31 exact", 64'(inexact_trap), 64'd0);
    convert(64'h8000_0000_0000_0000, 1'b1, 1'b1, M_NE, 1'b1);
    check("R3 -2^63 double", result, 64'hC3E0_0000_0000_0000);
    check("R3 -2^63 exact", 64'(inexact_trap), 64'd0);
    convert(64'h8000_0000_0000_0000, 1'b1, 1'b0, M_UP, 1'b1);
    check("R3 -2^63 single", result, 64'hDF00_0000);
  endtask

  task automatic t_round_modes();
    // 2^24+1: exact half, LSB even
    convert(64'd16777217, 1'b0, 1'b0, M_NE, 1'b0);
    check("R8 tie even stays", result, 64'h4B80_0000);
    convert(64'd16777217, 1'b0, 1'b0, M_RZ, 1'b0);
    check("R6 toward zero truncates", result, 64'h4B80_0000);
    convert(64'd16777217, 1'b0, 1'b0, M_UP, 1'b0);
    check("R7 +inf positive bumps", result, 64'h4B80_0001);
    convert(64'd16777217, 1'b0, 1'b0, M_DN, 1'b0);
    check("R7 -inf positive truncates", result, 64'h4B80_0000);
    // 2^24+3: exact half, LSB odd
    convert(64'd16777219, 1'b0, 1'b0, M_NE, 1'b0);
    check("R8 tie odd rounds up", result, 64'h4B80_0002);
    // -(2^24+1)
    convert(64'hFFFF_FFFF_FEFF_FFFF, 1'b0, 1'b0, M_DN, 1'b0);
    check("R7 -inf negative bumps", result, 64'hCB80_0001);
    convert(64'hFFFF_FFFF_FEFF_FFFF, 1'b0, 1'b0, M_UP, 1'b0);
    check("R7 +inf negative truncates", result, 64'hCB80_0000);
    // 2^53+1 into double
    convert(64'h0020_0000_0000_0001, 1'b1, 1'b1, M_NE, 1'b0);
    check("R8 double tie even", result, 64'h4340_0000_0000_0000);
    convert(64'h0020_0000_0000_0001, 1'b1, 1'b1, M_UP, 1'b0);
    check("R7 double +inf bumps", result, 64'h4340_0000_0000_0001);
  endtask

  task automatic t_carry();
    convert(64'h7FFF_FFFF, 1'b0, 1'b0, M_NE, 1'b0);
    check("R9 carry into exponent", result, 64'h4F00_0000);
    convert(64'h7FFF_FFFF, 1'b0, 1'b0, M_RZ, 1'b0);
    check("R9 truncated all-ones fraction", result, 64'h4EFF_FFFF);
  endtask

  task automatic t_widen_exact();
    clear_flag();
    convert(64'h7FFF_FFFF, 1'b0, 1'b1, M_UP, 1'b1);
    check("R10 32-bit to double value", result, 64'h41DF_FFFF_FFC0_0000);
    check("R10 no trap", 64'(inexact_trap), 64'd0);
    check("R10 no sticky", 64'(inexact_sticky), 64'd0);
  endtask

  task automatic t_trap();
    clear_flag();
    convert(64'd16777219, 1'b0, 1'b0, M_NE, 1'b1);
    check("R11 trapped result still delivered", result, 64'h4B80_0002);
    check("R11 trap pulse high", 64'(inexact_trap), 64'd1);
    check("R11 sticky untouched", 64'(inexact_sticky), 64'd0);
    @(negedge clk);
    check("R11 trap pulse one cycle", 64'(inexact_trap), 64'd0);
  endtask

  task automatic t_sticky();
    clear_flag();
    convert(64'd16777217, 1'b0, 1'b0, M_RZ, 1'b0);
    check("R12 sticky set", 64'(inexact_sticky), 64'd1);
    check("R12 no trap", 64'(inexact_trap), 64'd0);
    convert(64'd1, 1'b0, 1'b0, M_NE, 1'b0);
    repeat (3) @(negedge clk);
    check("R13 sticky holds", 64'(inexact_sticky), 64'd1);
    clear_flag();
    check("R13 clear", 64'(inexact_sticky), 64'd0);
    @(negedge clk);
    src_data = 64'd16777217; src_is_64 = 1'b0; dst_is_dbl = 1'b0; rnd_mode = M_NE;
    trap_en = 1'b0; in_valid = 1'b1; clr_inexact = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr_inexact = 1'b0;
    check("R13 set beats clear", 64'(inexact_sticky), 64'd1);
  endtask

  task automatic t_latency();
    @(negedge clk);
    check("R5 idle out_valid low", 64'(out_valid), 64'd0);
    src_data = 64'd2; src_is_64 = 1'b0; dst_is_dbl = 1'b1; rnd_mode = M_NE;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 out_valid after one edge", 64'(out_valid), 64'd1);
    check("R5 result 2.0 double", result, 64'h4000_0000_0000_0000);
    @(negedge clk);
    check("R5 out_valid drops", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sign_basic();
    t_zero();
    t_most_negative();
    t_round_modes();
    t_carry();
    t_widen_exact();
    t_trap();
    t_sticky();
    t_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule